// File: doc/BRIEF.md
# Serial Slave Front-End with Pause and Strap Address

This block is the bit-level front end of a small control device that is reached over a four-wire serial bus (select, clock, data in, data out). It also has an active-low pause input. All four bus inputs are asynchronous to the local system clock. They pass through two-flop synchronisers, and the bus clock edges are found in the system clock domain, so the serial clock is just another sampled signal.

A transaction opens on a falling edge of the select line. The first eight bits form an address byte. Its upper nibble must equal a device identifier parameter, and its two lowest bits must equal two pin-strapped address inputs. When both match, every later byte of the transaction is handed to a command decoder as a parallel byte with a one-cycle strobe. For each of those bytes the decoder may also offer a byte to send back. That byte leaves the chip MSB first on the data-out pin, which drives only while it has something to send, so the data-in and data-out lines can share one wire.

The pause input freezes a transaction in place without losing its progress. Raising the select line ends or aborts the transaction at once.

Top module: `spi_hold_slave`

## Requirements
- R1: While and right after reset, `so_oe`, `rx_valid` and `addr_hit` are 0.
- R2: Data-in is sampled on each rising bus clock edge, MSB first. After the eighth bit of each byte that follows a matching address byte, `rx_data` holds the byte and `rx_valid` is high for exactly one system clock. The strobe appears on the third system clock edge after the bus clock rise reaches the block.
- R3: The first byte of a transaction is the address byte. It matches when bits 7:4 equal `DEV_ID` (default 4'b1010) and bits 1:0 equal `addr_pins`. Bits 3:2 are don't-care. On a match `addr_hit` goes high and stays high until select rises.
- R4: After a non-matching address byte, the transaction is ignored: no `rx_valid` strobe, `addr_hit` stays 0 and `so_oe` stays 0 until select rises.
- R5: After reset, the block accepts no transaction until it has seen a high-to-low edge on `cs_n`. If `cs_n` is already low at reset, bus clock edges are ignored until `cs_n` goes high and low again.
- R6: In a matched transaction, the falling bus clock edge that begins each data byte loads `tx_data` and samples `tx_valid`. `so` then shows bit 7, and each later falling edge advances one bit toward bit 0. `so_oe` equals the sampled `tx_valid` for that byte.
- R7: `so_oe` is 0 while `cs_n` is high (within three system clocks) and while the transaction is paused.
- R8: A pause starts only when `hold_n` falls while the bus clock is low, and ends only when `hold_n` rises while the bus clock is low. While paused, bus clock edges are ignored and the bit position and both shift registers keep their values.
- R9: A fall of `hold_n` while the bus clock is high does not start a pause. Bits clocked afterwards, with `hold_n` still low, are received normally.
- R10: Raising `cs_n` mid-byte aborts the transaction. The bit position clears, `addr_hit` drops, no strobe is given for the partial byte, and the next transaction starts at bit 0 with a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Bus clock, asynchronous |
| cs_n | input | 1 | Bus select, active low, asynchronous |
| hold_n | input | 1 | Pause request, active low, asynchronous |
| si | input | 1 | Serial data in |
| addr_pins | input | ADDR_W | Pin-strapped slave address |
| tx_data | input | DATA_W | Byte offered by the decoder for the next data byte |
| tx_valid | input | 1 | Decoder wants `tx_data` sent |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the data-out pad |
| rx_data | output | DATA_W | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| addr_hit | output | 1 | Address byte matched in the open transaction |

## Verification
Every bus input passes two synchroniser flops and then one state register, so each result is due three system clocks after its input changes. The bench drives the bus with four system clocks per half period and samples four clocks after each change. Under that rule, `so` and `so_oe` are read just before the next rising bus edge, and the strobe count is read four clocks after the eighth rise. Select and pause effects are read four clocks after their edge, which leaves one clock of margin everywhere and no sampling on an edge.

// File: rtl/spi_hold_pkg.sv
// Shared constants for the serial slave front-end.
// Assumes: the four bus inputs are packed into one vector for synchronising.
package spi_hold_pkg;
    localparam int SYNC_W   = 4;
    localparam int IDX_SCK  = 0;
    localparam int IDX_CS   = 1;
    localparam int IDX_HOLD = 2;
    localparam int IDX_SI   = 3;
endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes: STAGES >= 2; every stage resets to 0 so no false select edge appears after reset.
module spi_in_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
// Transaction framing: arming on a select fall, pause tracking, bit position.
// Assumes: inputs are already synchronised; one edge event per system clock at most.
module spi_frame_ctrl #(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_lvl,
    input  logic             cs_n_lvl,
    input  logic             hold_n_lvl,
    output logic             active,
    output logic             held,
    output logic             step_rise,
    output logic             step_fall,
    output logic             byte_done,
    output logic             first_byte,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic sck_prev, cs_n_prev, hold_n_prev;
    logic sck_rise, sck_fall, cs_fall, hold_fall, hold_rise;

    // Remember last synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev    <= 1'b0;
            cs_n_prev   <= 1'b0;
            hold_n_prev <= 1'b0;
        end else begin
            sck_prev    <= sck_lvl;
            cs_n_prev   <= cs_n_lvl;
            hold_n_prev <= hold_n_lvl;
        end
    end

    // Edge events in the system clock domain.
    always_comb begin
        sck_rise  = sck_lvl & ~sck_prev;
        sck_fall  = ~sck_lvl & sck_prev;
        cs_fall   = ~cs_n_lvl & cs_n_prev;
        hold_fall = ~hold_n_lvl & hold_n_prev;
        hold_rise = hold_n_lvl & ~hold_n_prev;
    end

    // Arm on a select fall; disarm whenever select is high.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_lvl) begin
            active <= 1'b0;
        end else if (cs_fall) begin
            active <= 1'b1;
        end
    end

    // Pause state changes only while the bus clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_lvl) begin
            held <= 1'b0;
        end else if (active && !sck_lvl) begin
            if (hold_fall) begin
                held <= 1'b1;
            end else if (hold_rise) begin
                held <= 1'b0;
            end
        end
    end

    // Qualified bus clock edges that advance the transaction.
    always_comb begin
        step_rise = active & ~held & ~cs_n_lvl & sck_rise;
        step_fall = active & ~held & ~cs_n_lvl & sck_fall;
        byte_done = step_rise & (bit_cnt == LAST_BIT);
    end

    // Bit position within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_lvl) begin
            bit_cnt <= '0;
        end else if (step_rise) begin
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Marks that the address byte is still being received.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_lvl) begin
            first_byte <= 1'b1;
        end else if (byte_done) begin
            first_byte <= 1'b0;
        end
    end

    AST_HOLD_FREEZES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(held) && !$past(cs_n_lvl)) |-> $stable(bit_cnt)); // R8
    AST_HOLD_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> !$past(sck_lvl)); // R8
    AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (bit_cnt == '0)); // R5
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_lvl) |-> (bit_cnt == '0 && !held && first_byte)); // R10
endmodule

// File: rtl/spi_shift_path.sv
// Receive and transmit shift registers plus the address comparison.
// Assumes: framing strobes come from spi_frame_ctrl in the same clock domain.
module spi_shift_path #(
    parameter  int               DATA_W = 8,
    parameter  int               ID_W   = 4,
    parameter  int               ADDR_W = 2,
    parameter  logic [ID_W-1:0]  DEV_ID = 4'b1010,
    localparam int               CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              si_lvl,
    input  logic              cs_n_lvl,
    input  logic              held,
    input  logic              step_rise,
    input  logic              step_fall,
    input  logic              byte_done,
    input  logic              first_byte,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              addr_hit,
    output logic              so,
    output logic              so_oe
);
    logic [DATA_W-2:0] rx_sh;
    logic [DATA_W-1:0] assembled;
    logic [DATA_W-1:0] tx_sh;
    logic              matched;
    logic              driving;
    logic              id_ok, pins_ok;

    // Byte as it stands including the bit being sampled now.
    always_comb begin
        assembled = {rx_sh, si_lvl};
        id_ok     = (assembled[DATA_W-1 -: ID_W] == DEV_ID);
        pins_ok   = (assembled[ADDR_W-1:0] == addr_pins);
    end

    // Shift in one bit per qualified rising bus clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (step_rise) begin
            rx_sh <= assembled[DATA_W-2:0];
        end
    end

    // Latch the address decision at the end of the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_lvl) begin
            matched <= 1'b0;
        end else if (byte_done && first_byte) begin
            matched <= id_ok & pins_ok;
        end
    end

    // Present completed data bytes with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= byte_done & ~first_byte & matched;
            if (byte_done && !first_byte && matched) begin
                rx_data <= assembled;
            end
        end
    end

    // Load at a byte start, otherwise advance one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_lvl) begin
            tx_sh   <= '0;
            driving <= 1'b0;
        end else if (step_fall && matched) begin
            if (bit_cnt == '0) begin
                tx_sh   <= tx_data;
                driving <= tx_valid;
            end else begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign so       = tx_sh[DATA_W-1];
    assign so_oe    = driving & ~held;
    assign addr_hit = matched;

    AST_STROBE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> matched); // R4
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2
    AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_lvl) |-> !so_oe); // R7
    AST_OE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> matched); // R6
endmodule

// File: rtl/spi_hold_slave.sv
// Top of the serial slave front-end: synchroniser, framing and shift path.
// Assumes: bus clock half period spans at least three system clocks.
module spi_hold_slave #(
    parameter int              DATA_W      = 8,
    parameter int              ID_W        = 4,
    parameter int              ADDR_W      = 2,
    parameter logic [ID_W-1:0] DEV_ID      = 4'b1010,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              hold_n,
    input  logic              si,
    input  logic [ADDR_W-1:0] addr_pins,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              so,
    output logic              so_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              addr_hit
);
    import spi_hold_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);

    logic [SYNC_W-1:0] raw_in, lvl;
    logic              active, held, step_rise, step_fall, byte_done, first_byte;
    logic [CNT_W-1:0]  bit_cnt;

    // Pack the asynchronous bus pins for the synchroniser.
    always_comb begin
        raw_in           = '0;
        raw_in[IDX_SCK]  = sck;
        raw_in[IDX_CS]   = cs_n;
        raw_in[IDX_HOLD] = hold_n;
        raw_in[IDX_SI]   = si;
    end

    spi_in_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (lvl)
    );

    spi_frame_ctrl #(.DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_lvl    (lvl[IDX_SCK]),
        .cs_n_lvl   (lvl[IDX_CS]),
        .hold_n_lvl (lvl[IDX_HOLD]),
        .active     (active),
        .held       (held),
        .step_rise  (step_rise),
        .step_fall  (step_fall),
        .byte_done  (byte_done),
        .first_byte (first_byte),
        .bit_cnt    (bit_cnt)
    );

    spi_shift_path #(.DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .si_lvl     (lvl[IDX_SI]),
        .cs_n_lvl   (lvl[IDX_CS]),
        .held       (held),
        .step_rise  (step_rise),
        .step_fall  (step_fall),
        .byte_done  (byte_done),
        .first_byte (first_byte),
        .bit_cnt    (bit_cnt),
        .addr_pins  (addr_pins),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .addr_hit   (addr_hit),
        .so         (so),
        .so_oe      (so_oe)
    );

    AST_ACTIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !$past(active)) |-> $past(!lvl[IDX_CS])); // R5
endmodule

// File: tb/spi_hold_slave_tb.sv
module spi_hold_slave_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, sck, cs_n, hold_n, si, tx_valid;
    logic [1:0] addr_pins;
    logic [7:0] tx_data;
    logic       so, so_oe, rx_valid, addr_hit;
    logic [7:0] rx_data;

    int         checks = 0;
    int         errors = 0;
    int         rx_cnt = 0;
    logic [7:0] rx_last = '0;
    logic       done = 1'b0;

    logic [7:0] pay_q [4];
    logic [7:0] tx_q  [4];
    logic       txv_q [4];
    int         n_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_hold_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
        .addr_pins(addr_pins), .tx_data(tx_data), .tx_valid(tx_valid),
        .so(so), .so_oe(so_oe), .rx_data(rx_data), .rx_valid(rx_valid), .addr_hit(addr_hit)
    );

    // Count strobes away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
    end

    function automatic logic exp_hit(input logic [7:0] b, input logic [1:0] p);
        return (b[7:4] == 4'b1010) && (b[1:0] == p);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        si = b;
        wait_clk(4);
        sck = 1'b1;
        wait_clk(4);
        sck = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] mosi, input logic exp_drive, input logic [7:0] exp_miso,
                             input logic exp_strobe, input logic [7:0] nxt_tx, input logic nxt_v,
                             input string req);
        int base;
        base = rx_cnt;
        for (int i = 7; i >= 0; i--) begin
            si = mosi[i];
            wait_clk(4);
            if (exp_drive) begin
                check({req, " oe"}, 32'(so_oe), 32'd1);
                check({req, " so bit"}, 32'(so), 32'(exp_miso[i]));
            end else begin
                check({req, " oe off"}, 32'(so_oe), 32'd0);
            end
            sck = 1'b1;
            wait_clk(4);
            if (i == 0) begin
                tx_data  = nxt_tx;
                tx_valid = nxt_v;
                check({req, " strobes"}, 32'(rx_cnt - base), 32'(exp_strobe));
                if (exp_strobe) check({req, " rx byte"}, 32'(rx_last), 32'(mosi));
            end
            sck = 1'b0;
        end
    endtask

    task automatic run_txn(input logic [7:0] abyte);
        logic m;
        m = exp_hit(abyte, addr_pins);
        cs_n = 1'b0;
        wait_clk(4);
        xfer_byte(abyte, 1'b0, 8'h00, 1'b0, tx_q[0], txv_q[0], m ? "R3" : "R4");
        check(m ? "R3 hit" : "R4 no hit", 32'(addr_hit), 32'(m));
        for (int j = 0; j < n_q; j++) begin
            xfer_byte(pay_q[j], m && txv_q[j], tx_q[j], m,
                      (j + 1 < n_q) ? tx_q[j+1] : 8'h00, (j + 1 < n_q) ? txv_q[j+1] : 1'b0,
                      m ? "R2 R6" : "R4");
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(4);
        check("R7 deselect oe", 32'(so_oe), 32'd0);
        check("R10 hit cleared", 32'(addr_hit), 32'd0);
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; hold_n = 1'b1; si = 1'b0;
        addr_pins = 2'b01; tx_data = 8'h00; tx_valid = 1'b0;
        wait_clk(5);
        check("R1 oe", 32'(so_oe), 32'd0);
        check("R1 strobe", 32'(rx_valid), 32'd0);
        check("R1 hit", 32'(addr_hit), 32'd0);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 oe after", 32'(so_oe), 32'd0);

        // R5: select already low at reset leaves the block unarmed
        rst_n = 1'b0; cs_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        xfer_byte({4'b1010, 2'b11, addr_pins}, 1'b0, 8'h00, 1'b0, 8'hFF, 1'b1, "R5");
        check("R5 no hit", 32'(addr_hit), 32'd0);
        xfer_byte(8'h77, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R5");
        cs_n = 1'b1;
        wait_clk(4);
        tx_valid = 1'b0;

        // Directed matched transaction after proper arming
        n_q = 2; pay_q[0] = 8'h81; pay_q[1] = 8'h3E;
        tx_q[0] = 8'hB4; txv_q[0] = 1'b1; tx_q[1] = 8'h6D; txv_q[1] = 1'b1;
        run_txn({4'b1010, 2'b10, addr_pins});

        // R3: wrong identifier nibble and wrong pins
        n_q = 1; pay_q[0] = 8'h55; tx_q[0] = 8'hF0; txv_q[0] = 1'b1;
        run_txn({4'b1011, 2'b00, addr_pins});
        run_txn({4'b1010, 2'b00, ~addr_pins});

        // R8: pause mid-byte while driving
        cs_n = 1'b0;
        wait_clk(4);
        xfer_byte({4'b1010, 2'b01, addr_pins}, 1'b0, 8'h00, 1'b0, 8'hA5, 1'b1, "R3");
        base = rx_cnt;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        wait_clk(4);
        check("R6 oe before pause", 32'(so_oe), 32'd1);
        hold_n = 1'b0;
        wait_clk(4);
        check("R7 oe paused", 32'(so_oe), 32'd0);
        send_bit(1'b1); send_bit(1'b1);
        hold_n = 1'b1;
        wait_clk(4);
        check("R8 oe resumed", 32'(so_oe), 32'd1);
        check("R8 so position kept", 32'(so), 32'd0);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        check("R8 one strobe", 32'(rx_cnt - base), 32'd1);
        check("R8 byte intact", 32'(rx_last), 32'h5A);
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(4);

        // R9: pause request while the bus clock is high is not recognised
        cs_n = 1'b0;
        tx_valid = 1'b0;
        wait_clk(4);
        xfer_byte({4'b1010, 2'b00, addr_pins}, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R3");
        base = rx_cnt;
        send_bit(1'b1); send_bit(1'b0);
        si = 1'b0;
        wait_clk(4);
        sck = 1'b1;
        wait_clk(2);
        hold_n = 1'b0;
        wait_clk(4);
        sck = 1'b0;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        check("R9 strobe", 32'(rx_cnt - base), 32'd1);
        check("R9 byte", 32'(rx_last), 32'h96);
        wait_clk(4);
        hold_n = 1'b1;
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(4);

        // R10: abort mid-byte, then a clean transaction
        cs_n = 1'b0;
        wait_clk(4);
        xfer_byte({4'b1010, 2'b00, addr_pins}, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, "R3");
        base = rx_cnt;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(4);
        check("R10 abort hit", 32'(addr_hit), 32'd0);
        check("R10 abort no strobe", 32'(rx_cnt - base), 32'd0);
        n_q = 1; pay_q[0] = 8'h3C; tx_q[0] = 8'hC9; txv_q[0] = 1'b1;
        run_txn({4'b1010, 2'b11, addr_pins});

        // Random transactions
        for (int t = 0; t < 30; t++) begin
            logic [7:0] ab;
            addr_pins = 2'($urandom);
            wait_clk(4);
            if ($urandom % 2 == 0) ab = {4'b1010, 2'($urandom), addr_pins};
            else ab = 8'($urandom);
            n_q = 1 + int'($urandom % 3);
            for (int k = 0; k < 4; k++) begin
                pay_q[k] = 8'($urandom);
                tx_q[k]  = 8'($urandom);
                txv_q[k] = ($urandom % 4) != 0;
            end
            run_txn(ab);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule